// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block sits beside the access controller of an EDO DRAM and keeps the array alive. After reset it holds the row strobe and both column strobes inactive for the power-up settle time. It then runs eight row-strobe wake-up pulses with the column strobes high. Only after that does it open the bus to normal traffic. From then on an interval timer adds one pending refresh for every slice of the retention window. The slice is the retention time divided by the row count, rounded down to whole clocks.

While any refresh is pending the block raises `ref_req`. The access controller finishes its current cycle, parks the bus and answers with `ref_gnt`. The sequencer then takes the strobes and runs one CAS-before-RAS cycle. The DRAM's own row counter picks the row, so no address is driven. The sequencer keeps `ref_req` up for as long as work remains. Every delay (settle time, strobe widths, lead time, precharge, refresh slice) is given in nanoseconds and converted to clocks from the clock-period parameter. If the access controller withholds the grant long enough for the pending count to reach its limit, a further interval tick raises a sticky starvation flag.

Top module: `drs_refresh_seq`

## Requirements
- R1: From reset, `ras_n`, `ucas_n` and `lcas_n` stay high for ceil(WAIT_NS·1000/CLK_PS) cycles after reset release (25000 cycles at the defaults).
- R2: After the settle time, exactly WAKE_N (8) row pulses follow. Each pulse has `ras_n` low for ceil(T_RAS_NS·1000/CLK_PS) cycles (7) and then high for ceil(T_RP_NS·1000/CLK_PS) cycles (4), with both column strobes high throughout.
- R3: `init_done` rises in the cycle after the last wake-up precharge ends. Before that, `acc_en` and `ref_req` are low. After it, `acc_en` equals `init_done` AND NOT `bus_own`.
- R4: A refresh cycle drives both column strobes low for ceil(T_CSR_NS·1000/CLK_PS) cycles (2) with `ras_n` high. Then `ras_n` is low for the row-pulse time with both column strobes still low. Then all strobes are high for the precharge time.
- R5: `we_n` is high in every cycle, including every refresh cycle.
- R6: Starting in the cycle after `init_done` rises, one refresh becomes pending every floor(RETAIN_NS·1000/(ROWS·CLK_PS)) cycles (1953 at the defaults). Under a grant that is always present, `ref_req` therefore rises exactly that many cycles apart.
- R7: `ref_req` is high while a refresh cycle runs, and also while the block is idle with a nonzero pending count. A refresh cycle starts in the cycle after `ref_gnt` is sampled high with `ref_req` high. `bus_own` is high for exactly the cycles of the refresh sequence. A grant with nothing pending starts nothing.
- R8: The pending count never exceeds PEND_MAX. An interval tick that finds it at PEND_MAX, with no refresh completing in the same cycle, sets `starve_err`, which stays high until reset.
- R9: During reset all strobes and `we_n` are high, and `init_done`, `acc_en`, `ref_req`, `bus_own` and `starve_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller hands the bus to the sequencer |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| bus_own | output | 1 | Sequencer is driving the strobes |
| ref_req | output | 1 | Sequencer wants the bus |
| acc_en | output | 1 | Normal accesses may be granted |
| init_done | output | 1 | Power-up sequence has finished |
| starve_err | output | 1 | Sticky: pending refreshes overflowed |

## Verification
The block is exercised with four grant behaviours after the full power-up sequence.

- A grant that is always high shows the bare refresh spacing and proves that an idle grant starts nothing.
- A grant that follows the request after several cycles separates the request-to-cycle start from the tick timing.
- A grant held low until the pending count saturates exposes the limit and the sticky flag.
- A return to the delayed grant then shows the backlog draining through back-to-back refresh cycles.

A second reset, taken while the flag is set, confirms that it clears. Throughout, a queue-based model predicts every strobe level cycle by cycle. This distinguishes wrong pulse widths, a wrong order of column and row strobes, and a wrong pending count.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    PH_WAIT,
    PH_WAKE_LO,
    PH_WAKE_HI,
    PH_IDLE,
    PH_CBR_CAS,
    PH_CBR_RAS,
    PH_CBR_PRE
  } phase_t;

  // nanoseconds to whole clocks, rounded up, never below one
  function automatic int ns_to_cyc(longint ns, longint clk_ps);
    longint c;
    c = (ns * 64'd1000 + clk_ps - 64'd1) / clk_ps;
    if (c < 64'd1) c = 64'd1;
    return int'(c);
  endfunction

  // refresh slice in clocks, rounded down so the window is never exceeded
  function automatic int slice_cyc(longint window_ns, longint rows, longint clk_ps);
    longint c;
    c = (window_ns * 64'd1000) / (rows * clk_ps);
    if (c < 64'd2) c = 64'd2;
    return int'(c);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/drs_tick_gen.sv
module drs_tick_gen #(
  parameter int GAP = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = $clog2(GAP + 1);

  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = (cnt == W'(GAP - 1));
  assign tick   = run & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= at_end ? '0 : cnt + W'(1);
    end
  end
endmodule

// File: rtl/drs_pend_ctr.sv
module drs_pend_ctr #(
  parameter int PEND_MAX = 8,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          done,
  output logic [PW-1:0] pend,
  output logic          pend_nz,
  output logic          starve_err
);
  logic at_lim;

  assign at_lim  = (pend == PW'(PEND_MAX));
  assign pend_nz = (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= '0;
      starve_err <= 1'b0;
    end else begin
      if (tick && !done) begin
        if (at_lim) starve_err <= 1'b1;
        else        pend       <= pend + PW'(1);
      end else if (!tick && done) begin
        pend <= pend - PW'(1);
      end
    end
  end
endmodule

// File: rtl/drs_phase_seq.sv
module drs_phase_seq
  import drs_pkg::*;
#(
  parameter int WAIT_CYC = 25000,
  parameter int WAKE_N   = 8,
  parameter int RAS_CYC  = 7,
  parameter int RP_CYC   = 4,
  parameter int CSR_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  input  logic pend_nz,
  output logic ras_n,
  output logic cas_n,
  output logic own,
  output logic init_done,
  output logic in_wait,
  output logic done
);
  localparam int TMAX = max3(WAIT_CYC, max3(RAS_CYC, RP_CYC, CSR_CYC), 1);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int WKW  = $clog2(WAKE_N + 1);

  phase_t         ph;
  logic [TW-1:0]  tmr;
  logic [WKW-1:0] wk;
  logic           expire;
  logic           last_wake;

  assign expire    = (tmr == '0);
  assign last_wake = (wk == WKW'(WAKE_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_WAIT;
      tmr <= TW'(WAIT_CYC - 1);
      wk  <= '0;
    end else begin
      case (ph)
        PH_WAIT: begin
          if (expire) begin
            ph  <= PH_WAKE_LO;
            tmr <= TW'(RAS_CYC - 1);
            wk  <= '0;
          end else tmr <= tmr - TW'(1);
        end
        PH_WAKE_LO: begin
          if (expire) begin
            ph  <= PH_WAKE_HI;
            tmr <= TW'(RP_CYC - 1);
          end else tmr <= tmr - TW'(1);
        end
        PH_WAKE_HI: begin
          if (expire) begin
            if (last_wake) begin
              ph <= PH_IDLE;
            end else begin
              ph  <= PH_WAKE_LO;
              tmr <= TW'(RAS_CYC - 1);
              wk  <= wk + WKW'(1);
            end
          end else tmr <= tmr - TW'(1);
        end
        PH_IDLE: begin
          if (pend_nz && gnt) begin
            ph  <= PH_CBR_CAS;
            tmr <= TW'(CSR_CYC - 1);
          end
        end
        PH_CBR_CAS: begin
          if (expire) begin
            ph  <= PH_CBR_RAS;
            tmr <= TW'(RAS_CYC - 1);
          end else tmr <= tmr - TW'(1);
        end
        PH_CBR_RAS: begin
          if (expire) begin
            ph  <= PH_CBR_PRE;
            tmr <= TW'(RP_CYC - 1);
          end else tmr <= tmr - TW'(1);
        end
        PH_CBR_PRE: begin
          if (expire) ph <= PH_IDLE;
          else        tmr <= tmr - TW'(1);
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign ras_n     = !(ph == PH_WAKE_LO || ph == PH_CBR_RAS);
  assign cas_n     = !(ph == PH_CBR_CAS || ph == PH_CBR_RAS);
  assign own       = (ph == PH_CBR_CAS || ph == PH_CBR_RAS || ph == PH_CBR_PRE);
  assign init_done = !(ph == PH_WAIT || ph == PH_WAKE_LO || ph == PH_WAKE_HI);
  assign in_wait   = (ph == PH_WAIT);
  assign done      = (ph == PH_CBR_PRE) && expire;
endmodule

// File: rtl/drs_refresh_seq.sv
module drs_refresh_seq
  import drs_pkg::*;
#(
  parameter int CLK_PS    = 8000,
  parameter int WAIT_NS   = 200000,
  parameter int WAKE_N    = 8,
  parameter int RETAIN_NS = 16000000,
  parameter int ROWS      = 1024,
  parameter int T_RAS_NS  = 50,
  parameter int T_RP_NS   = 30,
  parameter int T_CSR_NS  = 10,
  parameter int PEND_MAX  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ras_n,
  output logic ucas_n,
  output logic lcas_n,
  output logic we_n,
  output logic bus_own,
  output logic ref_req,
  output logic acc_en,
  output logic init_done,
  output logic starve_err
);
  localparam int WAIT_CYC = ns_to_cyc(longint'(WAIT_NS), longint'(CLK_PS));
  localparam int RAS_CYC  = ns_to_cyc(longint'(T_RAS_NS), longint'(CLK_PS));
  localparam int RP_CYC   = ns_to_cyc(longint'(T_RP_NS), longint'(CLK_PS));
  localparam int CSR_CYC  = ns_to_cyc(longint'(T_CSR_NS), longint'(CLK_PS));
  localparam int REF_GAP  = slice_cyc(longint'(RETAIN_NS), longint'(ROWS), longint'(CLK_PS));
  localparam int PW       = $clog2(PEND_MAX + 1);

  // internal events, named for the checker
  logic          tick;
  logic          done;
  logic          in_wait;
  logic          pend_nz;
  logic [PW-1:0] pend;
  logic          cas_n_i;

  drs_tick_gen #(.GAP(REF_GAP)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (init_done),
    .tick (tick)
  );

  drs_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .done      (done),
    .pend      (pend),
    .pend_nz   (pend_nz),
    .starve_err(starve_err)
  );

  drs_phase_seq #(
    .WAIT_CYC(WAIT_CYC),
    .WAKE_N  (WAKE_N),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC),
    .CSR_CYC (CSR_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt      (ref_gnt),
    .pend_nz  (pend_nz),
    .ras_n    (ras_n),
    .cas_n    (cas_n_i),
    .own      (bus_own),
    .init_done(init_done),
    .in_wait  (in_wait),
    .done     (done)
  );

  assign ucas_n  = cas_n_i;
  assign lcas_n  = cas_n_i;
  assign we_n    = 1'b1;
  assign acc_en  = init_done & ~bus_own;
  assign ref_req = bus_own | (init_done & pend_nz);
endmodule

// File: rtl/drs_refresh_seq_chk.sv
module drs_refresh_seq_chk #(
  parameter int PEND_MAX = 8,
  parameter int GAP      = 1953,
  parameter int WAKE_N   = 8,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          ucas_n,
  input logic          lcas_n,
  input logic          bus_own,
  input logic          ref_req,
  input logic          ref_gnt,
  input logic          acc_en,
  input logic          init_done,
  input logic          starve_err,
  input logic          in_wait,
  input logic          tick,
  input logic [PW-1:0] pend
);
  logic ras_prev;
  int   wake_seen;
  int   gap_cnt;
  logic gap_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev  <= 1'b1;
      wake_seen <= 0;
      gap_cnt   <= 0;
      gap_valid <= 1'b0;
    end else begin
      ras_prev <= ras_n;
      if (!init_done && ras_prev && !ras_n) wake_seen <= wake_seen + 1;
      if (tick) begin
        gap_cnt   <= 0;
        gap_valid <= 1'b1;
      end else begin
        gap_cnt <= gap_cnt + 1;
      end
    end
  end

  assert_quiet_settle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (ras_n && ucas_n && lcas_n));

  assert_wake_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (wake_seen == WAKE_N));

  assert_gate_before_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (!acc_en && !ref_req && !bus_own));

  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && init_done) |-> (!$past(ucas_n) && !$past(lcas_n)));

  assert_slice_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gap_valid) |-> (gap_cnt == GAP - 1));

  assert_start_needs_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> ($past(ref_gnt) && $past(ref_req)));

  assert_no_access_while_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> (!acc_en && ref_req));

  assert_pend_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(PEND_MAX));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    starve_err |=> starve_err);
endmodule

bind drs_refresh_seq drs_refresh_seq_chk #(
  .PEND_MAX(PEND_MAX),
  .GAP     (REF_GAP),
  .WAKE_N  (WAKE_N)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (ras_n),
  .ucas_n    (ucas_n),
  .lcas_n    (lcas_n),
  .bus_own   (bus_own),
  .ref_req   (ref_req),
  .ref_gnt   (ref_gnt),
  .acc_en    (acc_en),
  .init_done (init_done),
  .starve_err(starve_err),
  .in_wait   (in_wait),
  .tick      (tick),
  .pend      (pend)
);

// File: tb/drs_refresh_seq_test.sv
`timescale 1ns/1ps
module drs_refresh_seq_test;
  localparam int PEND_LIM = 4;
  localparam int CLKP     = 8000;
  localparam int WAIT_C   = (200000 * 1000 + CLKP - 1) / CLKP;
  localparam int RAS_C    = (50 * 1000 + CLKP - 1) / CLKP;
  localparam int RP_C     = (30 * 1000 + CLKP - 1) / CLKP;
  localparam int CSR_C    = (10 * 1000 + CLKP - 1) / CLKP;
  localparam longint GAP_L = (64'd16000000 * 64'd1000) / (64'd1024 * CLKP);
  localparam int GAP_C    = int'(GAP_L);

  typedef struct packed {
    bit       ras_n;
    bit       cas_n;
    bit       own;
    bit       pre_init;
    bit       last;
    bit [3:0] tag;
  } ent_t;

  localparam ent_t IDLE_E = '{ras_n: 1'b1, cas_n: 1'b1, own: 1'b0, pre_init: 1'b0, last: 1'b0, tag: 4'd7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ras_n, ucas_n, lcas_n, we_n, bus_own, ref_req, acc_en, init_done, starve_err;

  always #4 clk = ~clk;

  drs_refresh_seq #(.PEND_MAX(PEND_LIM)) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n),
    .bus_own(bus_own), .ref_req(ref_req), .acc_en(acc_en),
    .init_done(init_done), .starve_err(starve_err)
  );

  int   total = 0;
  int   bad = 0;
  bit   finished = 0;
  ent_t q[$];
  int   m_pend = 0;
  int   m_ivl = 0;
  bit   m_err = 0;
  bit   mdl_ok = 0;
  int   mode = 0;
  int   dly = 0;
  int   cyc = 0;
  int   last_rise = -1;
  bit   prev_req = 0;
  bit   prev_ras = 1;
  int   wake_falls = 0;

  ent_t cur;
  bit   busy, initd, tick;
  int   p0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic string tag_name(bit [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd4: return "R4";
      default: return "R7";
    endcase
  endfunction

  // behavioural reference: a queue of upcoming strobe patterns
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < WAIT_C; i++) q.push_back('{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1});
      for (int k = 0; k < 8; k++) begin
        for (int i = 0; i < RAS_C; i++) q.push_back('{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2});
        for (int i = 0; i < RP_C; i++)  q.push_back('{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2});
      end
      m_pend = 0;
      m_ivl  = 0;
      m_err  = 0;
      mdl_ok = 1;
    end else if (mdl_ok) begin
      busy  = (q.size() != 0);
      cur   = busy ? q[0] : IDLE_E;
      initd = !cur.pre_init;
      tick  = initd && (m_ivl == GAP_C - 1);
      if (initd) m_ivl = tick ? 0 : m_ivl + 1;
      p0 = m_pend;
      if (tick && !cur.last) begin
        if (m_pend == PEND_LIM) m_err = 1;
        else m_pend++;
      end else if (!tick && cur.last) begin
        m_pend--;
      end
      if (busy) void'(q.pop_front());
      else if (p0 != 0 && ref_gnt) begin
        for (int i = 0; i < CSR_C; i++) q.push_back('{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4});
        for (int i = 0; i < RAS_C; i++) q.push_back('{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4});
        for (int i = 0; i < RP_C; i++)
          q.push_back('{1'b1, 1'b1, 1'b1, 1'b0, (i == RP_C - 1), 4'd4});
      end
    end
  end

  // compare every cycle away from the active edge, then drive the grant
  always @(negedge clk) begin
    ent_t e;
    cyc++;
    if (mdl_ok && rst_n) begin
      e = (q.size() != 0) ? q[0] : IDLE_E;
      chk(tag_name(e.tag), {ras_n, ucas_n, lcas_n}, {e.ras_n, e.cas_n, e.cas_n});
      chk("R5 we_n", we_n, 1);
      chk("R3 init_done/acc_en", {init_done, acc_en}, {!e.pre_init, !e.pre_init && !e.own});
      chk("R6 R7 ref_req/bus_own", {ref_req, bus_own},
          {e.own || ((q.size() == 0) && m_pend != 0), e.own});
      chk("R8 starve_err", starve_err, m_err);
      if (!init_done && prev_ras && !ras_n) wake_falls++;
      if (mode == 1 && ref_req && !prev_req) begin
        if (last_rise >= 0) chk("R6 request spacing", cyc - last_rise, GAP_C);
        last_rise = cyc;
      end
      if (mode != 1) last_rise = -1;
    end
    prev_req = ref_req;
    prev_ras = ras_n;
    case (mode)
      1: ref_gnt <= 1'b1;
      2: begin
        if (ref_req) dly++;
        else dly = 0;
        ref_gnt <= (dly >= 5);
      end
      default: ref_gnt <= 1'b0;
    endcase
  end

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    run_cycles(3);
    // R9 reset state
    chk("R9 strobes in reset", {ras_n, ucas_n, lcas_n, we_n}, 4'hf);
    chk("R9 flags in reset", {init_done, acc_en, ref_req, bus_own}, 0);
    chk("R9 starve_err in reset", starve_err, 0);
    #1 rst_n = 1'b1;
    run_cycles(WAIT_C - 2);
    chk("R1 still settling", {init_done, ras_n}, 2'b01);
    run_cycles(8 * (RAS_C + RP_C) + 4);
    chk("R2 wake pulse count", wake_falls, 8);
    chk("R3 init_done after wake", init_done, 1);
    mode = 1;
    run_cycles(4 * GAP_C + 20);
    mode = 2;
    run_cycles(4 * GAP_C);
    mode = 0;
    run_cycles((PEND_LIM + 2) * GAP_C);
    chk("R8 starvation flagged", starve_err, 1);
    chk("R7 request held while starved", ref_req, 1);
    mode = 2;
    run_cycles(2 * GAP_C);
    chk("R8 flag stays set", starve_err, 1);
    #1 rst_n = 1'b0;
    run_cycles(3);
    chk("R9 R8 flag cleared by reset", {starve_err, init_done}, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule